// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block performs exception entry for a 32-bit coprocessor-0 style control unit. A pipeline raises a one-cycle request with an exception type code, the PC of the faulting instruction and a flag that says whether that instruction sits in a branch delay slot. On the next clock edge the unit commits every state change the exception calls for. It saves the return address into one of three return registers (general, error or debug). It updates the status bits for exception level, error level, bootstrap vectors, NMI, soft reset, user mode and debug mode. It writes the cause fields, which are the delay-slot bit, the 5-bit exception code and the coprocessor number, and it sets the sticky debug cause flags. In the same cycle it pulses a redirect strobe together with the new fetch address.

The fetch address is formed from a vector base and an offset. The offset depends on the exception kind, on whether the unit was already at exception level, and on the interrupt-vector bit. The pipeline clears its own delay-slot flag when it sees the redirect strobe. Returning from an exception and arbitration between simultaneous exceptions are handled elsewhere. The requester presents at most one exception per cycle.

Type code encoding on `type_i` (decimal): 0 interrupt, 1 modify, 2 TLB load invalid, 3 TLB store invalid, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 23 watch, 24 machine check, 16 TLB load refill, 17 TLB store refill, 18 NMI, 19 soft reset, 20 debug single step, 21 debug interrupt, 22 debug instruction break, 25 debug breakpoint instruction, 26 debug data break store, 27 debug data break load. The codes 14 and 28 to 31 are unknown.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous active-low reset, all three return registers, the exception code, the coprocessor number, the debug flags, and the EXL, ERL, BEV, NMI, SR, debug-mode, BD and redirect outputs read 0, and user mode reads 1.
- R2: For a general exception taken with EXL clear, the general return register receives PC-4 and BD is set to 1 when the delay flag is 1. Otherwise it receives PC and BD is cleared. EXL becomes 1 in both cases.
- R3: For a general exception taken with EXL already 1, the general return register and BD keep their values.
- R4: A general exception writes the exception code. This is the type code itself for types 0-13, 15, 23 and 24, code 2 for type 16, and code 3 for type 17. Unknown types 14 and 28-31 are taken as reserved instruction, which is code 10.
- R5: Type 11 writes `cu_num_i` into the coprocessor-number field. No other type changes that field.
- R6: The general vector is base plus 0x180. The base is 0xBFC00200 when BEV is 1, and otherwise `ebase_i` with bits 9:0 cleared.
- R7: The refill types 16 and 17 use offset 0x000 when EXL was clear before entry, and 0x180 otherwise. An interrupt (type 0, outside debug mode) uses offset 0x200 when `iv_i` is 1.
- R8: NMI (18) and soft reset (19) set the NMI or SR bit respectively. They write the error return register with the delay-slot rule of R2, set ERL and BEV, clear BD only when EXL is clear, leave the exception code unchanged, and redirect to 0xBFC00000.
- R9: Debug types set their sticky flag in `dbg_flags_o`. The bit positions are single step 0, breakpoint 1, data load 2, data store 3, instruction break 4 and interrupt 5. These types write the debug return register with the delay-slot rule, except that single step always stores PC unadjusted. They set debug mode, clear BD only when EXL is clear, and redirect to 0xBFC00480.
- R10: An interrupt (type 0) requested while debug mode is 1 is handled as a debug interrupt, as described in R9 with flag bit 5.
- R11: Every request clears user mode. Every register update and the redirect strobe appear together on the cycle after the request. A cycle without a request changes no register and gives no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | One-cycle exception request |
| type_i | input | 5 | Exception type code |
| pc_i | input | 32 | PC of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction is in a delay slot |
| iv_i | input | 1 | Interrupts use the dedicated vector offset |
| ebase_i | input | 32 | Exception base address |
| cu_num_i | input | 2 | Unusable coprocessor number |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | New fetch address |
| epc_o | output | 32 | General return address |
| errorepc_o | output | 32 | Error return address |
| depc_o | output | 32 | Debug return address |
| exl_o | output | 1 | Exception level |
| erl_o | output | 1 | Error level |
| bev_o | output | 1 | Bootstrap vectors |
| nmi_o | output | 1 | NMI entry seen |
| sr_o | output | 1 | Soft reset entry seen |
| um_o | output | 1 | User mode |
| dm_o | output | 1 | Debug mode |
| bd_o | output | 1 | Cause delay-slot bit |
| exccode_o | output | 5 | Cause exception code |
| ce_o | output | 2 | Cause coprocessor number |
| dbg_flags_o | output | 6 | Sticky debug cause flags |

## Verification
The assertions check the timing contract on every cycle. A request always produces the strobe on the next cycle, and the strobe never appears without one. Idle cycles leave the return register and the level bits untouched, and user mode is clear whenever the strobe is high. They also check that a general entry at exception level keeps EPC and BD, that debug flags never drop, and that an NMI entry lands on the error vector with ERL and BEV set. Only the bench scenarios can show the arithmetic content. That covers the exact vector for each base and offset combination, the exception code for every type including the unknown ones, the PC-4 adjustment and its single-step exception, and the conversion of an interrupt into a debug interrupt in debug mode.

// File: rtl/exc_entry_pkg.sv
// Package: shared widths, type codes, classes and vector constants for the
// exception entry unit. Assumes a 32-bit address space.
package exc_entry_pkg;
    localparam int XLEN   = 32;
    localparam int TYPE_W = 5;
    localparam int CODE_W = 5;
    localparam int CE_W   = 2;
    localparam int DBG_W  = 6;
    localparam int DBG_IW = $clog2(DBG_W);

    typedef enum logic [1:0] {
        CLS_GEN = 2'd0,
        CLS_ERR = 2'd1,
        CLS_DBG = 2'd2
    } exc_cls_e;

    localparam logic [TYPE_W-1:0] TY_INT     = 5'd0;
    localparam logic [TYPE_W-1:0] TY_MOD     = 5'd1;
    localparam logic [TYPE_W-1:0] TY_TLBL    = 5'd2;
    localparam logic [TYPE_W-1:0] TY_TLBS    = 5'd3;
    localparam logic [TYPE_W-1:0] TY_ADEL    = 5'd4;
    localparam logic [TYPE_W-1:0] TY_ADES    = 5'd5;
    localparam logic [TYPE_W-1:0] TY_IBE     = 5'd6;
    localparam logic [TYPE_W-1:0] TY_DBE     = 5'd7;
    localparam logic [TYPE_W-1:0] TY_SYS     = 5'd8;
    localparam logic [TYPE_W-1:0] TY_BRK     = 5'd9;
    localparam logic [TYPE_W-1:0] TY_RI      = 5'd10;
    localparam logic [TYPE_W-1:0] TY_CPU     = 5'd11;
    localparam logic [TYPE_W-1:0] TY_OVF     = 5'd12;
    localparam logic [TYPE_W-1:0] TY_TRAP    = 5'd13;
    localparam logic [TYPE_W-1:0] TY_FPE     = 5'd15;
    localparam logic [TYPE_W-1:0] TY_TLBL_RF = 5'd16;
    localparam logic [TYPE_W-1:0] TY_TLBS_RF = 5'd17;
    localparam logic [TYPE_W-1:0] TY_NMI     = 5'd18;
    localparam logic [TYPE_W-1:0] TY_SRST    = 5'd19;
    localparam logic [TYPE_W-1:0] TY_DSS     = 5'd20;
    localparam logic [TYPE_W-1:0] TY_DINT    = 5'd21;
    localparam logic [TYPE_W-1:0] TY_DIB     = 5'd22;
    localparam logic [TYPE_W-1:0] TY_WATCH   = 5'd23;
    localparam logic [TYPE_W-1:0] TY_MCHK    = 5'd24;
    localparam logic [TYPE_W-1:0] TY_DBP     = 5'd25;
    localparam logic [TYPE_W-1:0] TY_DDBS    = 5'd26;
    localparam logic [TYPE_W-1:0] TY_DDBL    = 5'd27;

    localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;
    localparam logic [CODE_W-1:0] CODE_RI   = 5'd10;

    localparam logic [DBG_IW-1:0] DB_DSS  = 3'd0;
    localparam logic [DBG_IW-1:0] DB_BP   = 3'd1;
    localparam logic [DBG_IW-1:0] DB_DDBL = 3'd2;
    localparam logic [DBG_IW-1:0] DB_DDBS = 3'd3;
    localparam logic [DBG_IW-1:0] DB_DIB  = 3'd4;
    localparam logic [DBG_IW-1:0] DB_DINT = 3'd5;

    localparam logic [XLEN-1:0] VEC_ERR     = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] VEC_BEV_GEN = 32'hBFC0_0200;
    localparam logic [XLEN-1:0] VEC_DBG     = 32'hBFC0_0480;
    localparam logic [XLEN-1:0] OFF_DEF     = 32'h0000_0180;
    localparam logic [XLEN-1:0] OFF_REFILL  = 32'h0000_0000;
    localparam logic [XLEN-1:0] OFF_IV      = 32'h0000_0200;
    localparam logic [XLEN-1:0] EBASE_LOW   = 32'h0000_03FF;
    localparam logic [XLEN-1:0] INSN_BYTES  = 32'd4;
endpackage

// File: rtl/exc_type_decode.sv
// Module: exc_type_decode
// Classifies an exception type code into general, error or debug entry and
// derives the exception code, the offset qualifiers and a one-hot debug flag.
// Assumes: an interrupt raised in debug mode is a debug interrupt; unknown
// codes are reserved instruction.
module exc_type_decode
    import exc_entry_pkg::*;
(
    input  logic [TYPE_W-1:0] type_i,
    input  logic              dm_i,
    output exc_cls_e          cls_o,
    output logic [CODE_W-1:0] code_o,
    output logic              refill_o,
    output logic              int_o,
    output logic              cpu_o,
    output logic              nmi_o,
    output logic              dss_o,
    output logic [DBG_W-1:0]  dbg_hot_o
);
    logic [DBG_IW-1:0] dbg_idx;

    // Map the type code to class, cause code and qualifiers.
    always_comb begin
        cls_o    = CLS_GEN;
        code_o   = CODE_RI;
        refill_o = 1'b0;
        int_o    = 1'b0;
        cpu_o    = 1'b0;
        nmi_o    = 1'b0;
        dss_o    = 1'b0;
        dbg_idx  = DB_DINT;
        case (type_i)
            TY_INT: begin
                if (dm_i) begin
                    cls_o = CLS_DBG;
                end else begin
                    code_o = CODE_INT;
                    int_o  = 1'b1;
                end
            end
            TY_MOD, TY_TLBL, TY_TLBS, TY_ADEL, TY_ADES, TY_IBE, TY_DBE,
            TY_SYS, TY_BRK, TY_RI, TY_OVF, TY_TRAP, TY_FPE, TY_WATCH,
            TY_MCHK: code_o = type_i;
            TY_CPU: begin
                code_o = type_i;
                cpu_o  = 1'b1;
            end
            TY_TLBL_RF: begin
                code_o   = CODE_TLBL;
                refill_o = 1'b1;
            end
            TY_TLBS_RF: begin
                code_o   = CODE_TLBS;
                refill_o = 1'b1;
            end
            TY_NMI: begin
                cls_o = CLS_ERR;
                nmi_o = 1'b1;
            end
            TY_SRST: cls_o = CLS_ERR;
            TY_DSS: begin
                cls_o   = CLS_DBG;
                dss_o   = 1'b1;
                dbg_idx = DB_DSS;
            end
            TY_DINT: begin
                cls_o   = CLS_DBG;
                dbg_idx = DB_DINT;
            end
            TY_DIB: begin
                cls_o   = CLS_DBG;
                dbg_idx = DB_DIB;
            end
            TY_DBP: begin
                cls_o   = CLS_DBG;
                dbg_idx = DB_BP;
            end
            TY_DDBS: begin
                cls_o   = CLS_DBG;
                dbg_idx = DB_DDBS;
            end
            TY_DDBL: begin
                cls_o   = CLS_DBG;
                dbg_idx = DB_DDBL;
            end
            default: code_o = CODE_RI;
        endcase
    end

    // One flag bit per debug cause, raised only for debug-class entries.
    for (genvar gi = 0; gi < DBG_W; gi++) begin : g_dbg_hot
        assign dbg_hot_o[gi] = (cls_o == CLS_DBG) && (dbg_idx == DBG_IW'(gi));
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Module: exc_vector_gen
// Computes the redirect address from the entry class, base selection and
// offset rules. Assumes exl_i is the exception level before this entry.
module exc_vector_gen
    import exc_entry_pkg::*;
(
    input  exc_cls_e        cls_i,
    input  logic            bev_i,
    input  logic            exl_i,
    input  logic            refill_i,
    input  logic            int_i,
    input  logic            iv_i,
    input  logic [XLEN-1:0] ebase_i,
    output logic [XLEN-1:0] vec_o
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Select base and offset, then form the final vector per class.
    always_comb begin
        base = bev_i ? VEC_BEV_GEN : (ebase_i & ~EBASE_LOW);
        if (refill_i && !exl_i) begin
            offset = OFF_REFILL;
        end else if (int_i && iv_i) begin
            offset = OFF_IV;
        end else begin
            offset = OFF_DEF;
        end
        case (cls_i)
            CLS_GEN: vec_o = base + offset;
            CLS_ERR: vec_o = VEC_ERR;
            default: vec_o = VEC_DBG;
        endcase
    end
endmodule

// File: rtl/exc_return_pc.sv
// Module: exc_return_pc
// Applies the delay-slot rule to the faulting PC: a delay-slot instruction
// returns to the preceding branch. Assumes fixed 4-byte instructions.
module exc_return_pc
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] pc_i,
    input  logic            in_delay_i,
    input  logic            no_adjust_i,
    output logic [XLEN-1:0] ret_pc_o
);
    // Step back one instruction only for an adjustable delay-slot fault.
    always_comb begin
        ret_pc_o = (in_delay_i && !no_adjust_i) ? (pc_i - INSN_BYTES) : pc_i;
    end
endmodule

// File: rtl/exc_entry_unit.sv
// Module: exc_entry_unit (top)
// Commits exception entry in one cycle: return register, status, cause and
// debug flags, together with a registered redirect strobe and address.
// Assumes at most one request per cycle; return from exception is external.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter logic BEV_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              in_delay_i,
    input  logic              iv_i,
    input  logic [XLEN-1:0]   ebase_i,
    input  logic [CE_W-1:0]   cu_num_i,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   errorepc_o,
    output logic [XLEN-1:0]   depc_o,
    output logic              exl_o,
    output logic              erl_o,
    output logic              bev_o,
    output logic              nmi_o,
    output logic              sr_o,
    output logic              um_o,
    output logic              dm_o,
    output logic              bd_o,
    output logic [CODE_W-1:0] exccode_o,
    output logic [CE_W-1:0]   ce_o,
    output logic [DBG_W-1:0]  dbg_flags_o
);
    exc_cls_e          dec_cls;
    logic [CODE_W-1:0] dec_code;
    logic              dec_refill;
    logic              dec_int;
    logic              dec_cpu;
    logic              dec_nmi;
    logic              dec_dss;
    logic [DBG_W-1:0]  dec_dbg_hot;
    logic [XLEN-1:0]   vec;
    logic [XLEN-1:0]   ret_pc;

    logic              redirect_q;
    logic [XLEN-1:0]   redirect_pc_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   errorepc_q;
    logic [XLEN-1:0]   depc_q;
    logic              exl_q;
    logic              erl_q;
    logic              bev_q;
    logic              nmi_q;
    logic              sr_q;
    logic              um_q;
    logic              dm_q;
    logic              bd_q;
    logic [CODE_W-1:0] code_q;
    logic [CE_W-1:0]   ce_q;
    logic [DBG_W-1:0]  dbg_q;

    exc_type_decode u_decode (
        .type_i    (type_i),
        .dm_i      (dm_q),
        .cls_o     (dec_cls),
        .code_o    (dec_code),
        .refill_o  (dec_refill),
        .int_o     (dec_int),
        .cpu_o     (dec_cpu),
        .nmi_o     (dec_nmi),
        .dss_o     (dec_dss),
        .dbg_hot_o (dec_dbg_hot)
    );

    exc_vector_gen u_vector (
        .cls_i    (dec_cls),
        .bev_i    (bev_q),
        .exl_i    (exl_q),
        .refill_i (dec_refill),
        .int_i    (dec_int),
        .iv_i     (iv_i),
        .ebase_i  (ebase_i),
        .vec_o    (vec)
    );

    exc_return_pc u_retpc (
        .pc_i        (pc_i),
        .in_delay_i  (in_delay_i),
        .no_adjust_i (dec_dss),
        .ret_pc_o    (ret_pc)
    );

    // Commit all entry state and the redirect in the cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_q    <= 1'b0;
            redirect_pc_q <= '0;
            epc_q         <= '0;
            errorepc_q    <= '0;
            depc_q        <= '0;
            exl_q         <= 1'b0;
            erl_q         <= 1'b0;
            bev_q         <= BEV_RESET;
            nmi_q         <= 1'b0;
            sr_q          <= 1'b0;
            um_q          <= 1'b1;
            dm_q          <= 1'b0;
            bd_q          <= 1'b0;
            code_q        <= '0;
            ce_q          <= '0;
            dbg_q         <= '0;
        end else begin
            redirect_q <= req_i;
            if (req_i) begin
                redirect_pc_q <= vec;
                um_q          <= 1'b0;
                case (dec_cls)
                    CLS_GEN: begin
                        if (!exl_q) begin
                            epc_q <= ret_pc;
                            bd_q  <= in_delay_i;
                            exl_q <= 1'b1;
                        end
                        code_q <= dec_code;
                        if (dec_cpu) begin
                            ce_q <= cu_num_i;
                        end
                    end
                    CLS_ERR: begin
                        errorepc_q <= ret_pc;
                        erl_q      <= 1'b1;
                        bev_q      <= 1'b1;
                        if (dec_nmi) begin
                            nmi_q <= 1'b1;
                        end else begin
                            sr_q <= 1'b1;
                        end
                        if (!exl_q) begin
                            bd_q <= 1'b0;
                        end
                    end
                    default: begin
                        depc_q <= ret_pc;
                        dm_q   <= 1'b1;
                        dbg_q  <= dbg_q | dec_dbg_hot;
                        if (!exl_q) begin
                            bd_q <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    assign redirect_o    = redirect_q;
    assign redirect_pc_o = redirect_pc_q;
    assign epc_o         = epc_q;
    assign errorepc_o    = errorepc_q;
    assign depc_o        = depc_q;
    assign exl_o         = exl_q;
    assign erl_o         = erl_q;
    assign bev_o         = bev_q;
    assign nmi_o         = nmi_q;
    assign sr_o          = sr_q;
    assign um_o          = um_q;
    assign dm_o          = dm_q;
    assign bd_o          = bd_q;
    assign exccode_o     = code_q;
    assign ce_o          = ce_q;
    assign dbg_flags_o   = dbg_q;
endmodule

// File: rtl/exc_entry_chk.sv
// Module: exc_entry_chk
// Property checker for exc_entry_unit, attached with bind. Observes ports
// and the decoder's class output.
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [1:0]       cls,
    input logic             redirect_o,
    input logic [XLEN-1:0]  redirect_pc_o,
    input logic [XLEN-1:0]  epc_o,
    input logic             exl_o,
    input logic             erl_o,
    input logic             bev_o,
    input logic             nmi_o,
    input logic             um_o,
    input logic             bd_o,
    input logic [DBG_W-1:0] dbg_flags_o
);
    assert_redirect_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> redirect_o);

    assert_no_spurious_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !redirect_o);

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(epc_o) && $stable(exl_o) && $stable(erl_o)));

    assert_user_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !um_o);

    assert_exl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && exl_o && cls == 2'(CLS_GEN)) |=> ($stable(epc_o) && $stable(bd_o)));

    assert_nmi_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> (redirect_pc_o == VEC_ERR && erl_o && bev_o));

    assert_dbg_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((dbg_flags_o & $past(dbg_flags_o)) == $past(dbg_flags_o)));
endmodule

bind exc_entry_unit exc_entry_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .cls           (dec_cls),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .exl_o         (exl_o),
    .erl_o         (erl_o),
    .bev_o         (bev_o),
    .nmi_o         (nmi_o),
    .um_o          (um_o),
    .bd_o          (bd_o),
    .dbg_flags_o   (dbg_flags_o)
);

// File: tb/exc_entry_unit_test.sv
// Bench for exc_entry_unit: directed corner cases plus seeded random requests,
// each compared against a reference state kept by bench functions.
module exc_entry_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [4:0]  type_i = '0;
    logic [31:0] pc_i = '0;
    logic        in_delay_i = 1'b0;
    logic        iv_i = 1'b0;
    logic [31:0] ebase_i = '0;
    logic [1:0]  cu_num_i = '0;
    logic        redirect_o;
    logic [31:0] redirect_pc_o, epc_o, errorepc_o, depc_o;
    logic        exl_o, erl_o, bev_o, nmi_o, sr_o, um_o, dm_o, bd_o;
    logic [4:0]  exccode_o;
    logic [1:0]  ce_o;
    logic [5:0]  dbg_flags_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_epc, m_eepc, m_depc, m_vec;
    logic        m_exl, m_erl, m_bev, m_nmi, m_sr, m_um, m_dm, m_bd;
    logic [4:0]  m_code;
    logic [1:0]  m_ce;
    logic [5:0]  m_dbg;

    always #10 clk = ~clk;

    exc_entry_unit uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .type_i(type_i), .pc_i(pc_i),
        .in_delay_i(in_delay_i), .iv_i(iv_i), .ebase_i(ebase_i), .cu_num_i(cu_num_i),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .epc_o(epc_o),
        .errorepc_o(errorepc_o), .depc_o(depc_o), .exl_o(exl_o), .erl_o(erl_o),
        .bev_o(bev_o), .nmi_o(nmi_o), .sr_o(sr_o), .um_o(um_o), .dm_o(dm_o),
        .bd_o(bd_o), .exccode_o(exccode_o), .ce_o(ce_o), .dbg_flags_o(dbg_flags_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // R4: expected exception code for a general-class type
    function automatic logic [4:0] exp_code(input logic [4:0] ty);
        case (ty)
            5'd16:                         return 5'd2;
            5'd17:                         return 5'd3;
            5'd14, 5'd28, 5'd29, 5'd30,
            5'd31:                         return 5'd10;
            default:                       return ty;
        endcase
    endfunction

    // R9: flag position for each debug type
    function automatic logic [5:0] dbg_bit(input logic [4:0] ty);
        case (ty)
            5'd20:   return 6'b000001;
            5'd25:   return 6'b000010;
            5'd27:   return 6'b000100;
            5'd26:   return 6'b001000;
            5'd22:   return 6'b010000;
            default: return 6'b100000;
        endcase
    endfunction

    function automatic bit is_dbg_type(input logic [4:0] ty);
        return ty == 5'd20 || ty == 5'd21 || ty == 5'd22 || ty == 5'd25 ||
               ty == 5'd26 || ty == 5'd27;
    endfunction

    task automatic model_reset();
        m_epc = '0; m_eepc = '0; m_depc = '0; m_vec = '0;
        m_exl = 0; m_erl = 0; m_bev = 0; m_nmi = 0; m_sr = 0;
        m_um = 1; m_dm = 0; m_bd = 0; m_code = '0; m_ce = '0; m_dbg = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic check_all(input string ptag, input string etag, input string dtag,
                             input logic exp_redirect);
        chk("R11", "redirect", redirect_o, exp_redirect);
        if (exp_redirect) chk(ptag, "vector", redirect_pc_o, m_vec);
        chk(etag, "epc", epc_o, m_epc);
        chk(etag, "bd", bd_o, m_bd);
        chk("R2", "exl", exl_o, m_exl);
        chk("R4", "exccode", exccode_o, m_code);
        chk("R5", "ce", ce_o, m_ce);
        chk("R8", "errorepc", errorepc_o, m_eepc);
        chk("R8", "erl", erl_o, m_erl);
        chk("R8", "bev", bev_o, m_bev);
        chk("R8", "nmi/sr", {nmi_o, sr_o}, {m_nmi, m_sr});
        chk(dtag, "depc", depc_o, m_depc);
        chk(dtag, "dm", dm_o, m_dm);
        chk(dtag, "dbg_flags", dbg_flags_o, m_dbg);
        chk("R11", "um", um_o, m_um);
    endtask

    task automatic do_req(input logic [4:0] ty, input logic [31:0] pc, input logic dly,
                          input logic iv, input logic [31:0] eb, input logic [1:0] cu);
        string ptag, etag, dtag;
        logic old_exl;
        logic [31:0] base, off;
        @(negedge clk);
        req_i = 1'b1; type_i = ty; pc_i = pc; in_delay_i = dly;
        iv_i = iv; ebase_i = eb; cu_num_i = cu;
        old_exl = m_exl;
        etag = old_exl ? "R3" : "R2";
        dtag = "R9";
        if (ty == 5'd18 || ty == 5'd19) begin
            m_eepc = dly ? pc - 32'd4 : pc;
            m_erl = 1; m_bev = 1;
            if (ty == 5'd18) m_nmi = 1; else m_sr = 1;
            if (!old_exl) m_bd = 0;
            m_vec = 32'hBFC00000;
            ptag = "R8"; etag = "R8";
        end else if (is_dbg_type(ty) || (ty == 5'd0 && m_dm)) begin
            m_depc = (dly && ty != 5'd20) ? pc - 32'd4 : pc;
            m_dm = 1;
            m_dbg = m_dbg | dbg_bit(ty);
            if (!old_exl) m_bd = 0;
            m_vec = 32'hBFC00480;
            ptag = (ty == 5'd0) ? "R10" : "R9";
            dtag = ptag; etag = ptag;
        end else begin
            base = m_bev ? 32'hBFC00200 : (eb & 32'hFFFFFC00);
            off = 32'h180;
            ptag = "R6";
            if ((ty == 5'd16 || ty == 5'd17) && !old_exl) begin
                off = 32'h0; ptag = "R7";
            end else if (ty == 5'd0 && iv) begin
                off = 32'h200; ptag = "R7";
            end
            m_vec = base + off;
            if (!old_exl) begin
                m_epc = dly ? pc - 32'd4 : pc;
                m_bd = dly;
                m_exl = 1;
            end
            m_code = exp_code(ty);
            if (ty == 5'd11) m_ce = cu;
        end
        m_um = 0;
        @(negedge clk);
        req_i = 1'b0;
        check_all(ptag, etag, dtag, 1'b1);
    endtask

    // R11: an idle cycle changes nothing and gives no redirect
    task automatic idle_check();
        @(negedge clk);
        check_all("R11", "R11", "R11", 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();
        @(negedge clk);
        check_all("R1", "R1", "R1", 1'b0);   // R1 reset state

        // R2 delay slot, then R3 with EXL already set
        do_req(5'd8, 32'h0000_1004, 1'b1, 1'b0, 32'h8000_0000, 2'd0);
        do_req(5'd9, 32'h0000_2000, 1'b0, 1'b0, 32'h8000_0000, 2'd0);
        idle_check();
        // R7 refill with EXL set keeps 0x180
        do_req(5'd16, 32'h0000_3000, 1'b0, 1'b0, 32'h8123_4567, 2'd0);
        do_reset();
        // R7 refill with EXL clear, R4 unknown type
        do_req(5'd17, 32'h0040_0010, 1'b0, 1'b0, 32'h8123_4567, 2'd0);
        do_req(5'd14, 32'h0040_0020, 1'b0, 1'b0, 32'h8123_4567, 2'd0);
        do_reset();
        // R7 interrupt with IV; R5 coprocessor number
        do_req(5'd0, 32'h0050_0000, 1'b0, 1'b1, 32'h9000_0000, 2'd0);
        do_req(5'd11, 32'h0050_0004, 1'b0, 1'b0, 32'h9000_0000, 2'd3);
        do_req(5'd12, 32'h0050_0008, 1'b0, 1'b0, 32'h9000_0000, 2'd1);
        do_reset();
        // R8 NMI from delay slot, then general entry on the bootstrap base (R6)
        do_req(5'd18, 32'h0060_0004, 1'b1, 1'b0, 32'h9000_0000, 2'd0);
        do_req(5'd4, 32'h0060_0100, 1'b0, 1'b0, 32'h9000_0000, 2'd0);
        do_req(5'd19, 32'h0060_0200, 1'b0, 1'b0, 32'h9000_0000, 2'd0);
        do_reset();
        // R9 single step in delay slot keeps PC; R10 interrupt in debug mode
        do_req(5'd20, 32'h0070_0004, 1'b1, 1'b0, 32'h9000_0000, 2'd0);
        do_req(5'd0, 32'h0070_0008, 1'b1, 1'b1, 32'h9000_0000, 2'd0);
        do_req(5'd26, 32'h0070_0010, 1'b1, 1'b0, 32'h9000_0000, 2'd0);
        idle_check();

        // seeded random mix
        for (int n = 0; n < 600; n++) begin
            if (n % 6 == 0) do_reset();
            do_req(5'($urandom_range(0, 31)), {$urandom() & 32'hFFFF_FFFC},
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   $urandom(), 2'($urandom_range(0, 3)));
            if ($urandom_range(0, 3) == 0) idle_check();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule